// File: doc/BRIEF.md
# Address-Phase Timeout Monitor

This block sits next to the arbiter of a shared bus and watches the address phase of every transfer. A transfer's address phase begins in the first cycle in which the arbiter's address-valid strobe is seen high while the monitor is idle. From that cycle on, the monitor counts clocks. On the last cycle of a fixed window of `WINDOW` cycles (16 by default), it looks at three things: whether any slave asked for a wait, whether any slave asked for re-arbitration, and whether the master aborted. If none of them is asserted, it raises a timeout for the master that owns the transfer. That timeout closes the address phase outright. No acknowledge is faked and no data phase follows.

A slave that is slow to decode can assert its wait signal at any point inside the window. This takes the transfer out of the timeout path for good. The address phase then lasts until a slave acknowledges the address or requests re-arbitration, or until the master aborts. The wait, rearbitrate and acknowledge inputs come from `N_SLAVES` slaves and are OR-combined before use. The timeout output is a one-hot vector of `N_MASTERS` bits. Alongside it, a single address-phase-done pulse marks the end of every address phase the monitor closes or sees closed.

Top module: `addr_timeout_monitor`

## Requirements
- R1: A synchronous active-high `rst` clears the window count, the suppression state and the owner. `timeout_o` and `phase_done_o` are 0 in the cycle after any reset edge, and the window restarts at cycle 1 with the first address-valid cycle after reset is released.
- R2: Cycle 1 of a phase is the first cycle in which `addr_valid` is high while the monitor is idle. The timeout decision is taken in cycle `WINDOW` (16 by default), never earlier.
- R3: If no wait, rearbitrate, acknowledge or abort has been seen in cycles 1 to `WINDOW`, then in the cycle after cycle `WINDOW` `timeout_o` carries a single 1 at bit `master_id` (the value sampled in cycle 1) for exactly one cycle. `phase_done_o` is high in that same cycle.
- R4: If any bit of `slv_addr_ack` or `slv_rearb` is high, or `master_abort` is high, in a cycle k from 1 to `WINDOW`, the phase ends. `phase_done_o` pulses in cycle k+1 and `timeout_o` stays all zero. An end event wins over a wait in the same cycle.
- R5: Any bit of `slv_wait` high in a cycle from 1 to `WINDOW` suppresses the timeout for the rest of that transfer, even after the wait drops again. No timeout is raised for that transfer.
- R6: After suppression, the phase ends only on an acknowledge, a rearbitrate or an abort. `phase_done_o` pulses in the cycle after that event.
- R7: If `addr_valid` drops in a counting phase before any end event or wait, the phase is abandoned with no output. The next address-valid cycle is counted as a fresh cycle 1.
- R8: The slave inputs are OR-reduced: every slave index has the same effect for wait, rearbitrate and acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_valid | input | 1 | Primary address valid from the arbiter |
| master_id | input | MID_W | Index of the master owning the transfer |
| master_abort | input | 1 | Owning master aborts the request |
| slv_wait | input | N_SLAVES | Per-slave wait request |
| slv_rearb | input | N_SLAVES | Per-slave re-arbitration request |
| slv_addr_ack | input | N_SLAVES | Per-slave address acknowledge |
| timeout_o | output | N_MASTERS | One-hot single-cycle timeout, bit = owner |
| phase_done_o | output | 1 | Single-cycle pulse: address phase closed |

## Verification
A window counter that is off by one shows directly at the ports. The timeout then appears one cycle early or late relative to cycle 16 of a held address-valid, so it is caught within one window. A suppression flag that is lost shows as a spurious timeout 16 cycles into a transfer whose wait dropped early. A flag that sticks shows as a missing timeout on the next transfer. A stale owner register shows up on the first timeout after the master index changes, as the wrong bit in `timeout_o`. Each of these is visible no later than one window plus one cycle after the faulty state is set.

// File: rtl/atm_pkg.sv
package atm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_COUNT = 2'd1,
    PH_HOLD  = 2'd2
  } phase_e;
endpackage

// File: rtl/atm_slave_merge.sv
module atm_slave_merge #(
  parameter int N_SLAVES = 3
) (
  input  logic [N_SLAVES-1:0] wait_v,
  input  logic [N_SLAVES-1:0] rearb_v,
  input  logic [N_SLAVES-1:0] ack_v,
  output logic                any_wait,
  output logic                any_rearb,
  output logic                any_ack
);
  assign any_wait  = |wait_v;
  assign any_rearb = |rearb_v;
  assign any_ack   = |ack_v;
endmodule

// File: rtl/atm_window_counter.sv
module atm_window_counter #(
  parameter int WINDOW = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_last
);
  localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (inc)     cnt_q <= cnt_q + 1'b1;
  end

  assign at_last = (cnt_q == LAST);
endmodule

// File: rtl/atm_onehot_decode.sv
module atm_onehot_decode #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [IW-1:0] idx,
  input  logic          en,
  output logic [N-1:0]  vec
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    assign vec[g] = en && (idx == IW'(g));
  end
endmodule

// File: rtl/addr_timeout_monitor.sv
module addr_timeout_monitor #(
  parameter int N_MASTERS = 4,
  parameter int N_SLAVES  = 3,
  parameter int WINDOW    = 16,
  localparam int MID_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 addr_valid,
  input  logic [MID_W-1:0]     master_id,
  input  logic                 master_abort,
  input  logic [N_SLAVES-1:0]  slv_wait,
  input  logic [N_SLAVES-1:0]  slv_rearb,
  input  logic [N_SLAVES-1:0]  slv_addr_ack,
  output logic [N_MASTERS-1:0] timeout_o,
  output logic                 phase_done_o
);
  import atm_pkg::*;

  phase_e             state_q, state_d;
  logic [MID_W-1:0]   owner_q, owner_now;
  logic               any_wait, any_rearb, any_ack, end_evt;
  logic               cnt_clr, cnt_inc, cnt_last;
  logic               fire_to, fire_done;
  logic [N_MASTERS-1:0] to_vec;

  atm_slave_merge #(.N_SLAVES(N_SLAVES)) u_merge (
    .wait_v   (slv_wait),
    .rearb_v  (slv_rearb),
    .ack_v    (slv_addr_ack),
    .any_wait (any_wait),
    .any_rearb(any_rearb),
    .any_ack  (any_ack)
  );

  atm_window_counter #(.WINDOW(WINDOW)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .clear  (cnt_clr),
    .inc    (cnt_inc),
    .at_last(cnt_last)
  );

  assign end_evt   = any_ack | any_rearb | master_abort;
  assign owner_now = (state_q == PH_IDLE) ? master_id : owner_q;

  always_comb begin
    state_d   = state_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;
    fire_to   = 1'b0;
    fire_done = 1'b0;
    unique case (state_q)
      PH_IDLE, PH_COUNT: begin
        if (!addr_valid) begin
          state_d = PH_IDLE;
          cnt_clr = 1'b1;
        end else if (end_evt) begin
          state_d   = PH_IDLE;
          cnt_clr   = 1'b1;
          fire_done = 1'b1;
        end else if (any_wait) begin
          state_d = PH_HOLD;
          cnt_clr = 1'b1;
        end else if (cnt_last) begin
          state_d   = PH_IDLE;
          cnt_clr   = 1'b1;
          fire_done = 1'b1;
          fire_to   = 1'b1;
        end else begin
          state_d = PH_COUNT;
          cnt_inc = 1'b1;
        end
      end
      PH_HOLD: begin
        if (end_evt) begin
          state_d   = PH_IDLE;
          cnt_clr   = 1'b1;
          fire_done = 1'b1;
        end
      end
      default: begin
        state_d = PH_IDLE;
        cnt_clr = 1'b1;
      end
    endcase
  end

  atm_onehot_decode #(.N(N_MASTERS), .IW(MID_W)) u_dec (
    .idx(owner_now),
    .en (fire_to),
    .vec(to_vec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= PH_IDLE;
      owner_q      <= '0;
      timeout_o    <= '0;
      phase_done_o <= 1'b0;
    end else begin
      state_q      <= state_d;
      timeout_o    <= to_vec;
      phase_done_o <= fire_done;
      if (state_q == PH_IDLE && addr_valid) owner_q <= master_id;
    end
  end
endmodule

// File: rtl/atm_checker.sv
module atm_checker #(
  parameter int N_MASTERS = 4,
  parameter int N_SLAVES  = 3,
  parameter int WINDOW    = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 addr_valid,
  input logic                 master_abort,
  input logic [N_SLAVES-1:0]  slv_wait,
  input logic [N_SLAVES-1:0]  slv_rearb,
  input logic [N_SLAVES-1:0]  slv_addr_ack,
  input logic [N_MASTERS-1:0] timeout_o,
  input logic                 phase_done_o
);
  localparam int RW = $clog2(WINDOW + 1);
  logic [RW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !addr_valid)            run_q <= '0;
    else if (run_q != RW'(WINDOW))     run_q <= run_q + 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (timeout_o == '0) && !phase_done_o);

  // R3
  onehot_to_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(timeout_o));

  // R3
  to_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_o != '0) |-> phase_done_o);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_o != '0) |=> (timeout_o == '0));

  // R4
  no_to_on_event_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_o != '0) |-> !$past(master_abort || (|slv_wait) || (|slv_rearb) || (|slv_addr_ack)));

  // R2
  window_len_chk: assert property (@(posedge clk) disable iff (rst)
    (timeout_o != '0) |-> (run_q >= RW'(WINDOW)));
endmodule

bind addr_timeout_monitor atm_checker #(
  .N_MASTERS(N_MASTERS),
  .N_SLAVES (N_SLAVES),
  .WINDOW   (WINDOW)
) u_atm_chk (
  .clk         (clk),
  .rst         (rst),
  .addr_valid  (addr_valid),
  .master_abort(master_abort),
  .slv_wait    (slv_wait),
  .slv_rearb   (slv_rearb),
  .slv_addr_ack(slv_addr_ack),
  .timeout_o   (timeout_o),
  .phase_done_o(phase_done_o)
);

// File: tb/test_addr_timeout_monitor.sv
module test_addr_timeout_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NM = 4;
  localparam int NS = 3;
  localparam int WIN = 16;

  // kind: 0 none, 1 ack, 2 rearb, 3 abort
  typedef struct packed {
    logic [1:0] mid;
    logic [5:0] wait_cyc;
    logic [5:0] end_cyc;
    logic [1:0] kind;
    logic [1:0] sidx;
    logic       exp_to;
    logic [5:0] exp_cyc;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 6'd0,  6'd0,  2'd0, 2'd0, 1'b1, 6'd16},
    '{2'd3, 6'd0,  6'd0,  2'd0, 2'd0, 1'b1, 6'd16},
    '{2'd1, 6'd5,  6'd25, 2'd1, 2'd2, 1'b0, 6'd25},
    '{2'd2, 6'd0,  6'd7,  2'd1, 2'd1, 1'b0, 6'd7},
    '{2'd1, 6'd0,  6'd16, 2'd2, 2'd2, 1'b0, 6'd16},
    '{2'd2, 6'd0,  6'd16, 2'd3, 2'd0, 1'b0, 6'd16},
    '{2'd0, 6'd16, 6'd20, 2'd2, 2'd1, 1'b0, 6'd20},
    '{2'd3, 6'd0,  6'd1,  2'd1, 2'd0, 1'b0, 6'd1},
    '{2'd2, 6'd0,  6'd3,  2'd3, 2'd0, 1'b0, 6'd3},
    '{2'd1, 6'd9,  6'd9,  2'd1, 2'd2, 1'b0, 6'd9}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          addr_valid = 1'b0;
  logic [1:0]    master_id = '0;
  logic          master_abort = 1'b0;
  logic [NS-1:0] slv_wait = '0;
  logic [NS-1:0] slv_rearb = '0;
  logic [NS-1:0] slv_addr_ack = '0;
  logic [NM-1:0] timeout_o;
  logic          phase_done_o;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_timeout_monitor #(.N_MASTERS(NM), .N_SLAVES(NS), .WINDOW(WIN)) i_addr_timeout_monitor (
    .clk(clk), .rst(rst), .addr_valid(addr_valid), .master_id(master_id),
    .master_abort(master_abort), .slv_wait(slv_wait), .slv_rearb(slv_rearb),
    .slv_addr_ack(slv_addr_ack), .timeout_o(timeout_o), .phase_done_o(phase_done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    addr_valid = 1'b0; master_abort = 1'b0;
    slv_wait = '0; slv_rearb = '0; slv_addr_ack = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    idle_inputs();
    repeat (3) tick();
    // R1: outputs after reset edges
    chk("R1 reset timeout", 32'(timeout_o), 0);
    chk("R1 reset done", 32'(phase_done_o), 0);
    rst = 1'b0;
    tick();

    // Table walk: R2 R3 R4 R5 R6 R8
    for (int v = 0; v < NV; v++) begin
      bit quiet_ok = 1'b1;
      for (int k = 1; k <= int'(VECS[v].exp_cyc); k++) begin
        idle_inputs();
        addr_valid = 1'b1;
        master_id  = (k == 1) ? VECS[v].mid : ~VECS[v].mid;
        if (k == int'(VECS[v].wait_cyc)) slv_wait[VECS[v].sidx] = 1'b1;
        if (k == int'(VECS[v].end_cyc)) begin
          case (VECS[v].kind)
            2'd1: slv_addr_ack[VECS[v].sidx] = 1'b1;
            2'd2: slv_rearb[VECS[v].sidx] = 1'b1;
            2'd3: master_abort = 1'b1;
            default: ;
          endcase
        end
        tick();
        if (k < int'(VECS[v].exp_cyc) && (timeout_o != '0 || phase_done_o)) quiet_ok = 1'b0;
      end
      chk($sformatf("R2 R5 vec%0d quiet before decision", v), 32'(quiet_ok), 1);
      chk($sformatf("R3 R4 R6 vec%0d timeout", v), 32'(timeout_o),
          VECS[v].exp_to ? (32'd1 << VECS[v].mid) : 32'd0);
      chk($sformatf("R3 R4 R6 R8 vec%0d done", v), 32'(phase_done_o), 1);
      idle_inputs();
      tick();
      chk($sformatf("R3 vec%0d single pulse", v), {31'd0, phase_done_o} | 32'(timeout_o), 0);
    end

    // R1: reset in the middle of a phase restarts the window
    master_id = 2'd2;
    addr_valid = 1'b1;
    repeat (10) tick();
    rst = 1'b1;
    tick();
    chk("R1 mid-phase reset quiet", {31'd0, phase_done_o} | 32'(timeout_o), 0);
    rst = 1'b0;
    for (int k = 1; k <= WIN; k++) begin
      tick();
      if (k == WIN - 1) chk("R1 R2 no early timeout after reset", 32'(timeout_o), 0);
    end
    chk("R1 R3 timeout after reset window", 32'(timeout_o), 32'd1 << 2);
    idle_inputs();
    tick();

    // R7: drop of address-valid abandons the phase
    begin
      bit quiet_ok = 1'b1;
      master_id = 2'd1;
      addr_valid = 1'b1;
      for (int k = 0; k < 8; k++) begin
        tick();
        if (timeout_o != '0 || phase_done_o) quiet_ok = 1'b0;
      end
      addr_valid = 1'b0;
      tick();
      if (timeout_o != '0 || phase_done_o) quiet_ok = 1'b0;
      addr_valid = 1'b1;
      for (int k = 1; k <= WIN; k++) begin
        tick();
        if (k < WIN && (timeout_o != '0 || phase_done_o)) quiet_ok = 1'b0;
      end
      chk("R7 abandon silent and recount", 32'(quiet_ok), 1);
      chk("R7 timeout after fresh window", 32'(timeout_o), 32'd1 << 1);
      idle_inputs();
      tick();
    end

    // R5: a wait that drops early does not re-enable the timeout
    begin
      bit quiet_ok = 1'b1;
      master_id = 2'd0;
      addr_valid = 1'b1;
      tick();
      slv_wait = 3'b001;
      tick();
      slv_wait = '0;
      for (int k = 0; k < 3 * WIN; k++) begin
        tick();
        if (timeout_o != '0 || phase_done_o) quiet_ok = 1'b0;
      end
      chk("R5 suppression persists", 32'(quiet_ok), 1);
      master_abort = 1'b1;
      tick();
      chk("R6 abort ends suppressed phase", 32'(phase_done_o), 1);
      idle_inputs();
      tick();
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule